// File: doc/BRIEF.md
# Video Black Level Servo

This block holds the black level of one digitized video channel at a fixed target. It watches the 8-bit pixel stream and starts one measurement per line on the trailing edge of horizontal sync. The measurement waits a programmable number of pixels, then averages a window of black pixels into a single per-line sample. Per-line samples are averaged over a group of lines. At the end of each group, the error against the black target, scaled by a loop gain, moves a 10-bit offset DAC code that drives an external analog DAC.

A mode input chooses between closed-loop and manual operation. In closed-loop mode a signed 8-bit user offset is added to every pixel, with saturation, to give the corrected output stream. In manual mode the DAC code is taken directly from a split manual value and the pixels pass through unchanged. A coast input from the line-locked PLL can block measurements, so that sync disturbances are not read as black. A half-range input doubles the loop step, which matches a DAC whose swing has been halved.

Top module: `black_servo`

## Requirements
- R1: While reset is asserted and just after it is released, dac_o is DAC_INIT (512) when loop_off_i is 0, and pix_o is 0.
- R2: With the loop enabled, a measurement starts on the first low cycle of hsync_i after it was high (pixel index k=0). The window covers pixels k = D .. D+N-1, where D = start_dly_i and N = 2^(win_sel_i+3). The per-line sample is the window sum shifted right by win_sel_i+3.
- R3: Per-line samples are summed over G = 2^line_sel_i completed lines. The group average is that sum shifted right by line_sel_i. dac_o changes only on the clock edge that takes the last window pixel of the G-th line. At that edge it moves by ((avg - BLACK_TGT) * 4) >>> GAIN_SHIFT, using an arithmetic shift (BLACK_TGT=16, GAIN_SHIFT=2 by default).
- R4: The updated servo code saturates at 0 and at 1023.
- R5: With coast_pass_i = 0, no measurement starts when coast_i is 1 on the trailing-edge cycle. With coast_pass_i = 1, coast_i has no effect.
- R6: If hsync_i goes high while a measurement is in progress, the measurement is dropped. The partial window does not count as a line of the group.
- R7: When loop_off_i = 1, dac_o equals {man_hi_i, man_lo_i} in the same cycle, no measurement runs, and the group is cleared. The servo code is kept and reappears when the loop is enabled again.
- R8: pix_o is registered one cycle after pix_i. With the loop enabled it is pix_i + user_ofs_i (two's complement) clamped to 0..255. With the loop disabled it is pix_i unchanged.
- R9: With half_rng_i = 1 the error multiplier is 8 instead of 4, in both the servo step and in the code the mode presents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_i | input | 8 | ADC pixel sample |
| hsync_i | input | 1 | Horizontal sync, active high |
| coast_i | input | 1 | PLL coasting flag |
| coast_pass_i | input | 1 | 1 allows measurements during coast |
| loop_off_i | input | 1 | 1 selects manual DAC mode |
| start_dly_i | input | 16 | Pixel delay from sync trailing edge to window |
| win_sel_i | input | 2 | Window width select, 2^(n+3) pixels |
| line_sel_i | input | 3 | Lines per group, 2^n |
| half_rng_i | input | 1 | Half DAC swing, doubles loop step |
| man_hi_i | input | 8 | Manual DAC code, upper bits |
| man_lo_i | input | 2 | Manual DAC code, lower bits |
| user_ofs_i | input | 8 | Signed digital offset in loop mode |
| dac_o | output | 10 | Offset DAC code |
| pix_o | output | 8 | Offset-corrected pixel |

## Verification
Pixels outside the nominal window are random and pixels inside it are a constant black value. A window shifted by a single pixel therefore moves the per-line average, and the test sweeps zero and non-zero delays across the narrowest and widest windows. Black values above and below the target, single-line groups against four-line groups, and both half-range settings separate the sign, size and timing of the step. Extreme blacks drive the code into both rails. Lines taken under coast, lines cut short by an early sync and lines in manual mode are each followed by target-level lines, so that a partial or forbidden sample shows up as a code change.

// File: rtl/black_servo_pkg.sv
package black_servo_pkg;
  typedef enum logic {WS_IDLE, WS_RUN} win_st_e;
endpackage

// File: rtl/bs_edge_gate.sv
module bs_edge_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic hsync_i,
  input  logic coast_i,
  input  logic coast_pass_i,
  output logic start_o
);
  logic hs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hs_q <= 1'b0;
    else         hs_q <= hsync_i;
  end

  // trailing edge, gated by mode and coast
  assign start_o = en_i && hs_q && !hsync_i && (coast_pass_i || !coast_i);
endmodule

// File: rtl/bs_window.sv
module bs_window
  import black_servo_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int DLY_W    = 16,
  parameter int WSEL_W   = 2,
  parameter int WIN_BASE = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              start_i,
  input  logic              hsync_i,
  input  logic [PIX_W-1:0]  pix_i,
  input  logic [DLY_W-1:0]  dly_i,
  input  logic [WSEL_W-1:0] wsel_i,
  output logic              busy_o,
  output logic              line_done_o,
  output logic [PIX_W-1:0]  line_avg_o
);
  localparam int POS_W = DLY_W + 1;
  localparam int SH_W  = WSEL_W + 1;
  localparam int SUM_W = PIX_W + WIN_BASE + (1 << WSEL_W) - 1;

  win_st_e           st_q;
  logic [POS_W-1:0]  pos_q, pos_cur, win_n, last_pos, dly_ext;
  logic [SUM_W-1:0]  sum_q, sum_cur, sum_nxt;
  logic [SH_W-1:0]   wsh;
  logic              active, abort, in_win, at_last;

  assign wsh      = SH_W'(WIN_BASE) + SH_W'(wsel_i);
  assign win_n    = POS_W'(1) << wsh;
  assign dly_ext  = POS_W'(dly_i);
  assign last_pos = dly_ext + win_n - POS_W'(1);

  assign abort   = (st_q == WS_RUN) && hsync_i;
  assign active  = ((st_q == WS_RUN) || start_i) && !abort && en_i;
  assign pos_cur = start_i ? '0 : pos_q;
  assign sum_cur = start_i ? '0 : sum_q;
  assign in_win  = active && (pos_cur >= dly_ext) && (pos_cur <= last_pos);
  assign at_last = active && (pos_cur == last_pos);
  assign sum_nxt = sum_cur + (in_win ? SUM_W'(pix_i) : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= WS_IDLE;
      pos_q <= '0;
      sum_q <= '0;
    end else if (!en_i || abort) begin
      st_q <= WS_IDLE;
    end else if (active) begin
      st_q  <= at_last ? WS_IDLE : WS_RUN;
      pos_q <= pos_cur + POS_W'(1);
      sum_q <= sum_nxt;
    end
  end

  assign busy_o      = (st_q == WS_RUN);
  assign line_done_o = at_last;
  assign line_avg_o  = PIX_W'(sum_nxt >> wsh);
endmodule

// File: rtl/bs_group.sv
module bs_group #(
  parameter int PIX_W      = 8,
  parameter int DAC_W      = 10,
  parameter int LSEL_W     = 3,
  parameter int BLACK_TGT  = 16,
  parameter int GAIN_SHIFT = 2,
  parameter int DAC_INIT   = 512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              line_done_i,
  input  logic [PIX_W-1:0]  line_avg_i,
  input  logic [LSEL_W-1:0] lsel_i,
  input  logic              half_i,
  output logic              upd_o,
  output logic [DAC_W-1:0]  dac_o
);
  localparam int CNT_W   = (1 << LSEL_W) - 1;
  localparam int GSUM_W  = PIX_W + CNT_W;
  localparam int SW      = DAC_W + PIX_W + 6;
  localparam int DAC_MAX = (1 << DAC_W) - 1;

  logic [CNT_W-1:0]     cnt_q;
  logic [CNT_W:0]       one_sh, lines_m1;
  logic [GSUM_W-1:0]    gsum_q, gsum_nxt;
  logic [PIX_W-1:0]     g_avg;
  logic [DAC_W-1:0]     dac_q, dac_nxt;
  logic signed [SW-1:0] avg_s, err_s, step_s, sum_s;
  logic                 last_line;

  assign one_sh    = (CNT_W+1)'(1) << lsel_i;
  assign lines_m1  = one_sh - (CNT_W+1)'(1);
  assign last_line = (cnt_q == lines_m1[CNT_W-1:0]);
  assign gsum_nxt  = gsum_q + GSUM_W'(line_avg_i);
  assign g_avg     = PIX_W'(gsum_nxt >> lsel_i);

  // signed error, gain x4 or x8, then arithmetic loop shift
  assign avg_s  = signed'(SW'(g_avg));
  assign err_s  = avg_s - SW'(BLACK_TGT);
  assign step_s = (half_i ? (err_s <<< 3) : (err_s <<< 2)) >>> GAIN_SHIFT;
  assign sum_s  = signed'(SW'(dac_q)) + step_s;

  always_comb begin
    if (sum_s < 0)                 dac_nxt = '0;
    else if (sum_s > SW'(DAC_MAX)) dac_nxt = DAC_W'(DAC_MAX);
    else                           dac_nxt = sum_s[DAC_W-1:0];
  end

  assign upd_o = en_i && line_done_i && last_line;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      gsum_q <= '0;
      dac_q  <= DAC_W'(DAC_INIT);
    end else if (!en_i) begin
      cnt_q  <= '0;
      gsum_q <= '0;
    end else if (line_done_i) begin
      if (last_line) begin
        cnt_q  <= '0;
        gsum_q <= '0;
        dac_q  <= dac_nxt;
      end else begin
        cnt_q  <= cnt_q + CNT_W'(1);
        gsum_q <= gsum_nxt;
      end
    end
  end

  assign dac_o = dac_q;
endmodule

// File: rtl/bs_pix_ofs.sv
module bs_pix_ofs #(
  parameter int PIX_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic [PIX_W-1:0]        pix_i,
  input  logic signed [PIX_W-1:0] ofs_i,
  output logic [PIX_W-1:0]        pix_o
);
  localparam int XW = PIX_W + 2;
  localparam int PMAX = (1 << PIX_W) - 1;

  logic signed [XW-1:0] sum_s;
  logic [PIX_W-1:0]     clip;

  assign sum_s = signed'(XW'(pix_i)) + XW'(ofs_i);

  always_comb begin
    if (sum_s < 0)             clip = '0;
    else if (sum_s > XW'(PMAX)) clip = PIX_W'(PMAX);
    else                       clip = sum_s[PIX_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pix_o <= '0;
    else         pix_o <= en_i ? clip : pix_i;
  end
endmodule

// File: rtl/black_servo.sv
module black_servo #(
  parameter int PIX_W      = 8,
  parameter int DAC_W      = 10,
  parameter int DLY_W      = 16,
  parameter int WSEL_W     = 2,
  parameter int LSEL_W     = 3,
  parameter int BLACK_TGT  = 16,
  parameter int GAIN_SHIFT = 2,
  parameter int DAC_INIT   = 512
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [PIX_W-1:0]        pix_i,
  input  logic                    hsync_i,
  input  logic                    coast_i,
  input  logic                    coast_pass_i,
  input  logic                    loop_off_i,
  input  logic [DLY_W-1:0]        start_dly_i,
  input  logic [WSEL_W-1:0]       win_sel_i,
  input  logic [LSEL_W-1:0]       line_sel_i,
  input  logic                    half_rng_i,
  input  logic [PIX_W-1:0]        man_hi_i,
  input  logic [DAC_W-PIX_W-1:0]  man_lo_i,
  input  logic signed [PIX_W-1:0] user_ofs_i,
  output logic [DAC_W-1:0]        dac_o,
  output logic [PIX_W-1:0]        pix_o
);
  logic             loop_en, start, win_busy, line_done, grp_upd;
  logic [PIX_W-1:0] line_avg;
  logic [DAC_W-1:0] servo_dac;

  assign loop_en = !loop_off_i;

  bs_edge_gate u_gate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (loop_en),
    .hsync_i      (hsync_i),
    .coast_i      (coast_i),
    .coast_pass_i (coast_pass_i),
    .start_o      (start)
  );

  bs_window #(.PIX_W(PIX_W), .DLY_W(DLY_W), .WSEL_W(WSEL_W)) u_win (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (loop_en),
    .start_i     (start),
    .hsync_i     (hsync_i),
    .pix_i       (pix_i),
    .dly_i       (start_dly_i),
    .wsel_i      (win_sel_i),
    .busy_o      (win_busy),
    .line_done_o (line_done),
    .line_avg_o  (line_avg)
  );

  bs_group #(
    .PIX_W(PIX_W), .DAC_W(DAC_W), .LSEL_W(LSEL_W), .BLACK_TGT(BLACK_TGT),
    .GAIN_SHIFT(GAIN_SHIFT), .DAC_INIT(DAC_INIT)
  ) u_grp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (loop_en),
    .line_done_i (line_done),
    .line_avg_i  (line_avg),
    .lsel_i      (line_sel_i),
    .half_i      (half_rng_i),
    .upd_o       (grp_upd),
    .dac_o       (servo_dac)
  );

  bs_pix_ofs #(.PIX_W(PIX_W)) u_ofs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (loop_en),
    .pix_i  (pix_i),
    .ofs_i  (user_ofs_i),
    .pix_o  (pix_o)
  );

  assign dac_o = loop_off_i ? {man_hi_i, man_lo_i} : servo_dac;
endmodule

// File: rtl/black_servo_chk.sv
module black_servo_chk #(
  parameter int DAC_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hsync_i,
  input logic             coast_i,
  input logic             coast_pass_i,
  input logic             loop_off_i,
  input logic             win_busy,
  input logic             line_done,
  input logic             grp_upd,
  input logic [DAC_W-1:0] dac_o
);
  logic hs_q, seen_q, hs_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q   <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      hs_q   <= hsync_i;
      seen_q <= 1'b1;
    end
  end

  assign hs_fall = hs_q && !hsync_i;

  AST_DAC_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !loop_off_i && !$past(loop_off_i) && !$past(grp_upd)) |-> $stable(dac_o)); // R3
  AST_UPD_AT_LINE_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_upd |-> line_done); // R3
  AST_NO_LINE_IN_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hsync_i |-> !line_done); // R6
  AST_ABORT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_busy && hsync_i) |=> !win_busy); // R6
  AST_COAST_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_fall && coast_i && !coast_pass_i && !win_busy) |=> !win_busy); // R5
  AST_MANUAL_PAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_off_i |=> !win_busy); // R7
  AST_MANUAL_NO_UPD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_off_i |-> !grp_upd); // R7
endmodule

bind black_servo black_servo_chk #(.DAC_W(DAC_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .hsync_i      (hsync_i),
  .coast_i      (coast_i),
  .coast_pass_i (coast_pass_i),
  .loop_off_i   (loop_off_i),
  .win_busy     (win_busy),
  .line_done    (line_done),
  .grp_upd      (grp_upd),
  .dac_o        (dac_o)
);

// File: tb/black_servo_bench.sv
module black_servo_bench;
  localparam int CLK_P = 10;
  localparam int TGT = 16;

  logic clk = 0, rst_n = 0;
  logic [7:0] pix = 0, man_hi = 0, ofs = 0;
  logic [1:0] man_lo = 0, wsel = 0;
  logic [2:0] lsel = 0;
  logic [15:0] dly = 0;
  logic hsync = 0, coast = 0, coast_pass = 0, loop_off = 0, half = 0;
  wire [9:0] dac_o;
  wire [7:0] pix_o;

  int total = 0, bad = 0;
  bit done = 0;
  string phase = "R1 reset";

  black_servo u_black_servo (
    .clk_i(clk), .rst_ni(rst_n), .pix_i(pix), .hsync_i(hsync), .coast_i(coast),
    .coast_pass_i(coast_pass), .loop_off_i(loop_off), .start_dly_i(dly),
    .win_sel_i(wsel), .line_sel_i(lsel), .half_rng_i(half), .man_hi_i(man_hi),
    .man_lo_i(man_lo), .user_ofs_i(ofs), .dac_o(dac_o), .pix_o(pix_o)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_dac, m_pix, m_k, m_wsum, m_gsum, m_gcnt;
  bit m_run, m_hs;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dac = 512; m_pix = 0; m_run = 0; m_hs = 0; m_gsum = 0; m_gcnt = 0;
      m_k = 0; m_wsum = 0;
    end else begin
      int n, v;
      n = 1 << (wsel + 3);
      if (loop_off) begin
        m_pix = pix;
        m_run = 0; m_gsum = 0; m_gcnt = 0;
      end else begin
        v = int'(pix) + int'($signed(ofs));
        m_pix = v < 0 ? 0 : (v > 255 ? 255 : v);
        if (m_run && hsync) m_run = 0;
        else if (m_hs && !hsync && (coast_pass || !coast)) begin
          m_run = 1; m_k = 0; m_wsum = 0;
        end
        if (m_run) begin
          if (m_k >= dly && m_k < dly + n) m_wsum += pix;
          if (m_k == dly + n - 1) begin
            m_run = 0;
            m_gsum += m_wsum >> (wsel + 3);
            m_gcnt++;
            if (m_gcnt == (1 << lsel)) begin
              int e, s;
              e = (m_gsum >> lsel) - TGT;
              s = (e * (half ? 8 : 4)) >>> 2;
              m_dac += s;
              if (m_dac < 0) m_dac = 0;
              if (m_dac > 1023) m_dac = 1023;
              m_gsum = 0; m_gcnt = 0;
            end
          end
          m_k++;
        end
      end
      m_hs = hsync;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (!done) begin
      int ed;
      ed = loop_off ? int'({man_hi, man_lo}) : m_dac;
      check(dac_o == ed, {phase, " dac"}, dac_o, ed);
      check(pix_o == m_pix, {phase, " pix"}, pix_o, m_pix);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic run_line(input int blk, input int act_len);
    int n;
    n = 1 << (wsel + 3);
    for (int i = 0; i < 8; i++) begin
      hsync = 1; pix = 8'($urandom_range(0, 255)); step();
    end
    for (int k = 0; k < act_len; k++) begin
      hsync = 0;
      pix = (k >= dly && k < dly + n) ? 8'(blk) : 8'($urandom_range(0, 255));
      step();
    end
  endtask

  task automatic lines(input int cnt, input int blk);
    for (int i = 0; i < cnt; i++) run_line(blk, int'(dly) + (1 << (wsel + 3)) + 6);
  endtask

  task automatic pix_case(input int p, input int o, input int exp, input string tag);
    ofs = 8'(o); pix = 8'(p); step();
    @(negedge clk);
    check(pix_o == exp, tag, pix_o, exp);
    step();
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      done = 1; bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(dac_o == 512, "R1 reset dac", dac_o, 512);
    check(pix_o == 0, "R1 reset pix", pix_o, 0);
    step(); rst_n = 1; step();

    phase = "R2 R3 D4 w0 L0";
    dly = 4; wsel = 0; lsel = 0; lines(4, 20);
    check(dac_o == 528, "R2 R3 four lines above target", dac_o, 528);

    phase = "R2 D0 w3";
    dly = 0; wsel = 3; lines(3, 10);
    check(dac_o == 510, "R2 widest window below target", dac_o, 510);

    phase = "R3 group of four";
    dly = 10; wsel = 1; lsel = 2; lines(3, 24);
    check(dac_o == 510, "R3 no update mid group", dac_o, 510);
    lines(1, 24);
    check(dac_o == 518, "R3 update at group end", dac_o, 518);

    phase = "R9 half range";
    lsel = 0; half = 1; lines(1, 17);
    check(dac_o == 520, "R9 doubled step", dac_o, 520);

    phase = "R4 saturation";
    dly = 4; wsel = 0; lines(3, 255);
    check(dac_o == 1023, "R4 upper rail", dac_o, 1023);
    lines(40, 0);
    check(dac_o == 0, "R4 lower rail", dac_o, 0);

    phase = "R5 coast";
    half = 0; coast = 1; coast_pass = 0; lines(2, 40);
    check(dac_o == 0, "R5 blocked under coast", dac_o, 0);
    coast_pass = 1; lines(1, 40);
    check(dac_o == 24, "R5 coast passed", dac_o, 24);
    coast = 0; coast_pass = 0;

    phase = "R6 abort";
    lsel = 1; run_line(255, 6);
    lines(2, 16);
    check(dac_o == 24, "R6 partial window dropped", dac_o, 24);
    lines(2, 20);
    check(dac_o == 28, "R6 group resumes", dac_o, 28);

    phase = "R7 manual";
    loop_off = 1; man_hi = 8'hA5; man_lo = 2'b10; step();
    @(negedge clk);
    check(dac_o == 662, "R7 manual code", dac_o, 662);
    lines(2, 255);
    check(dac_o == 662, "R7 no servo in manual", dac_o, 662);
    loop_off = 0; step();
    @(negedge clk);
    check(dac_o == 28, "R7 servo code kept", dac_o, 28);

    phase = "R8 pixel offset";
    pix_case(200, 100, 255, "R8 clamp high");
    pix_case(50, -100, 0, "R8 clamp low");
    pix_case(10, 5, 15, "R8 in range");
    loop_off = 1;
    pix_case(77, 100, 77, "R8 passthrough in manual");
    loop_off = 0;

    repeat (4) step();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule